// File: doc/BRIEF.md
# Polled Queue-Status Flag Bus Scanner

This block presents the almost-full flags of a bank of queues on a narrow status bus. The per-queue flag vector is cut into status words of one bus width each. Word 1 carries queues 0 to 7 with queue 0 in bit 0, word 2 carries queues 8 to 15, and so on. One of two operating modes is latched while reset is held.

In polled mode the device loads its words onto the bus one per clock edge, in order. It raises a sync pulse while its first word is visible. Several devices can share one bus through a token ring. A device starts a pass over its words only when it holds the token. While it shows its last word, it drives the token to the next device. Between passes it releases the bus through an output-enable signal. A lone device loops its token output back to its own token input, so it polls without pause. The device marked as ring head at reset starts the first pass.

In direct mode the bus user picks one word with a strobe and a word address. That word stays selected, and is refreshed every cycle from the live flags, until the next accepted strobe. Strobes are ignored until the configuration-done input is high.

Top module: `qstat_flag_scanner`

## Requirements
- R1: The mode input is captured while reset is held (1 = polled, 0 = direct). Changes on the mode input after reset have no effect.
- R2: Status word k (k = 1..NUM_Q/BUS_W) carries the flags of queues BUS_W*(k-1) to BUS_W*k-1, and bus bit j carries queue BUS_W*(k-1)+j.
- R3: In polled mode, while the device holds the token, successive clock edges load words 1, 2, 3, 4. When token-out is looped to token-in, the next edge loads word 1 again. Each word holds the flag values sampled at the edge that loaded it.
- R4: The sync output is high exactly in the cycles in which the device's word 1 is on the bus.
- R5: The token output is high exactly in the cycles in which the device's last word is on the bus.
- R6: When token-in is low at the edge that ends the last word, the device goes idle: output enable low, bus all zero, sync and token low. An idle device loads word 1 on the first edge at which token-in is high.
- R7: A polled device whose ring-head input is high during reset loads word 1 on the first functional clock edge after reset release. A device that is not ring head stays idle until it receives the token.
- R8: In direct mode, an edge with strobe and configuration-done both high selects word (address + 1), and the bus shows that word's flags after that edge. The selection is kept and refreshed from the live flags on every later edge until the next accepted strobe. After reset, word 1 is selected.
- R9: In direct mode, a strobe while configuration-done is low is ignored, and the previous selection stays on the bus.
- R10: In direct mode the token input is ignored, sync and token outputs stay low, and output enable stays high.
- R11: While reset is held, the bus is all zero and the sync and token outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | Mode select, captured during reset: 1 polled, 0 direct |
| ring_head_i | input | 1 | Captured during reset: device starts the first polling pass |
| cfg_done_i | input | 1 | Configuration complete; direct strobes are accepted only when high |
| flags_i | input | NUM_Q | Per-queue almost-full flags, queue q on bit q |
| strobe_i | input | 1 | Direct-mode word select strobe |
| addr_i | input | WSEL_W | Direct-mode word address (0 selects word 1) |
| token_i | input | 1 | Token from the previous device in the ring |
| bus_o | output | BUS_W | Status bus |
| bus_oe_o | output | 1 | High while this device drives the status bus |
| sync_o | output | 1 | High while word 1 of this device is on the bus |
| token_o | output | 1 | Token to the next device, high during the last word |

## Verification
The bench builds the block with its defaults: 32 queues on an 8-bit bus, four status words, and a two-stage reset synchronizer. With four words, a full polling pass and its wrap back to word 1 fit in a few cycles. Every word index and the two-bit address wrap are reached both through the direct strobe and through the polling order. The bench drives the token input either looped from token-out or by hand. This lets it reach the ring-head start, the idle gap when the token is withheld, and the re-entry on a single token pulse.

// File: rtl/qsf_pkg.sv
package qsf_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_POLLED = 1'b1
  } qsf_mode_e;

endpackage

// File: rtl/qsf_rst_sync.sv
module qsf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/qsf_word_mux.sv
module qsf_word_mux #(
  parameter int NUM_WORDS = 4,
  parameter int BUS_W     = 8,
  parameter int WSEL_W    = 2
) (
  input  logic [NUM_WORDS*BUS_W-1:0] flags_i,
  input  logic [WSEL_W-1:0]          sel_i,
  output logic [BUS_W-1:0]           word_o
);

  logic [BUS_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slice
    assign words[g] = flags_i[g*BUS_W +: BUS_W];
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (sel_i == WSEL_W'(i)) begin
        word_o = words[i];
      end
    end
  end

endmodule

// File: rtl/qsf_poll_seq.sv
module qsf_poll_seq #(
  parameter int NUM_WORDS = 4,
  parameter int WSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              cfg_load_i,
  input  logic              poll_en_i,
  input  logic              head_i,
  input  logic              token_i,
  output logic              active_o,
  output logic [WSEL_W-1:0] idx_o,
  output logic              active_nxt_o,
  output logic [WSEL_W-1:0] idx_nxt_o
);

  localparam logic [WSEL_W-1:0] LAST_IDX = WSEL_W'(NUM_WORDS - 1);

  logic              active_q, active_d;
  logic [WSEL_W-1:0] idx_q, idx_d;
  logic              start_q;
  logic              start_en;

  // start credit: loaded during reset, consumed by the first functional edge
  assign start_en = cfg_load_i | start_q;

  always_ff @(posedge clk) begin
    if (start_en) begin
      start_q <= cfg_load_i & head_i;
    end
  end

  always_comb begin
    active_d = 1'b0;
    idx_d    = '0;
    if (poll_en_i) begin
      if (active_q && (idx_q != LAST_IDX)) begin
        active_d = 1'b1;
        idx_d    = WSEL_W'(idx_q + 1'b1);
      end else if (token_i || start_q) begin
        active_d = 1'b1;
        idx_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  assign active_o     = active_q;
  assign idx_o        = idx_q;
  assign active_nxt_o = active_d;
  assign idx_nxt_o    = idx_d;

endmodule

// File: rtl/qstat_flag_scanner.sv
module qstat_flag_scanner
  import qsf_pkg::*;
#(
  parameter int NUM_Q       = 32,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_WORDS   = NUM_Q / BUS_W,
  parameter int WSEL_W      = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              ring_head_i,
  input  logic              cfg_done_i,
  input  logic [NUM_Q-1:0]  flags_i,
  input  logic              strobe_i,
  input  logic [WSEL_W-1:0] addr_i,
  input  logic              token_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic              bus_oe_o,
  output logic              sync_o,
  output logic              token_o
);

  localparam logic [WSEL_W-1:0] LAST_IDX = WSEL_W'(NUM_WORDS - 1);

  logic              rst_sync_n;
  qsf_mode_e         mode_q;
  logic              poll_q;
  logic              active_q, active_nxt;
  logic [WSEL_W-1:0] idx_q, idx_nxt;
  logic [WSEL_W-1:0] sel_q, sel_d;
  logic              dir_take;
  logic [WSEL_W-1:0] mux_sel;
  logic [BUS_W-1:0]  mux_word;
  logic [BUS_W-1:0]  bus_q, bus_d;

  qsf_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // configuration capture: follows the input only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_sync_n) begin
      mode_q <= qsf_mode_e'(mode_i);
    end
  end

  assign poll_q = (mode_q == MODE_POLLED);

  qsf_poll_seq #(.NUM_WORDS(NUM_WORDS), .WSEL_W(WSEL_W)) seq_i (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .cfg_load_i   (!rst_sync_n),
    .poll_en_i    (poll_q),
    .head_i       (ring_head_i),
    .token_i      (token_i),
    .active_o     (active_q),
    .idx_o        (idx_q),
    .active_nxt_o (active_nxt),
    .idx_nxt_o    (idx_nxt)
  );

  // direct selection path
  assign dir_take = !poll_q && strobe_i && cfg_done_i;
  assign sel_d    = dir_take ? addr_i : sel_q;
  assign mux_sel  = poll_q ? idx_nxt : sel_d;

  qsf_word_mux #(.NUM_WORDS(NUM_WORDS), .BUS_W(BUS_W), .WSEL_W(WSEL_W)) mux_i (
    .flags_i (flags_i[NUM_WORDS*BUS_W-1:0]),
    .sel_i   (mux_sel),
    .word_o  (mux_word)
  );

  always_comb begin
    bus_d = mux_word;
    if (poll_q && !active_nxt) begin
      bus_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
    end else if (dir_take) begin
      sel_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_q <= '0;
    end else begin
      bus_q <= bus_d;
    end
  end

  assign bus_o    = bus_q;
  assign bus_oe_o = poll_q ? active_q : 1'b1;
  assign sync_o   = poll_q && active_q && (idx_q == '0);
  assign token_o  = poll_q && active_q && (idx_q == LAST_IDX);

endmodule

// File: rtl/qsf_scanner_chk.sv
module qsf_scanner_chk #(
  parameter int BUS_W  = 8,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              poll_q,
  input logic              cfg_done_i,
  input logic              token_i,
  input logic [WSEL_W-1:0] sel_q,
  input logic [BUS_W-1:0]  bus_o,
  input logic              bus_oe_o,
  input logic              sync_o,
  input logic              token_o
);

  // R1: captured mode is frozen once reset is released
  a_r1_mode_locked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> $stable(poll_q));

  // R3: looped token restarts the pass at word 1
  a_r3_loop_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (token_o && token_i) |=> sync_o);

  // R4: word 1 lasts exactly one cycle
  a_r4_sync_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sync_o |=> !sync_o);

  // R5: token out only while driving, never together with word 1
  a_r5_token_driving: assert property (@(posedge clk) disable iff (!rst_sync_n)
    token_o |-> (bus_oe_o && !sync_o));

  // R6: an idle device keeps the bus quiet
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_oe_o |-> ((bus_o == '0) && !sync_o && !token_o));

  // R9: no selection change before configuration is done
  a_r9_no_early_select: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!poll_q && !cfg_done_i) |=> $stable(sel_q));

  // R10: direct mode never pulses sync or token and always drives
  a_r10_direct_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !poll_q |-> (!sync_o && !token_o && bus_oe_o));

endmodule

bind qstat_flag_scanner qsf_scanner_chk #(.BUS_W(BUS_W), .WSEL_W(WSEL_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .poll_q     (poll_q),
  .cfg_done_i (cfg_done_i),
  .token_i    (token_i),
  .sel_q      (sel_q),
  .bus_o      (bus_o),
  .bus_oe_o   (bus_oe_o),
  .sync_o     (sync_o),
  .token_o    (token_o)
);

// File: tb/qstat_flag_scanner_tb_top.sv
module qstat_flag_scanner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_Q      = 32;
  localparam int BUS_W      = 8;
  localparam int WSEL_W     = 2;

  localparam logic [31:0] FL_A = 32'hA5C3_1E7F;
  localparam logic [31:0] FL_B = 32'h1234_5678;

  typedef struct packed {
    logic              stb;
    logic              done;
    logic [WSEL_W-1:0] adr;
    logic [NUM_Q-1:0]  fl;
    logic [BUS_W-1:0]  exp;
  } vec_t;

  // direct-mode walk: strobe, cfg done, address, flags, expected bus
  localparam vec_t TBL [9] = '{
    '{1'b0, 1'b0, 2'd3, FL_A, 8'h7F},
    '{1'b1, 1'b0, 2'd2, FL_A, 8'h7F},
    '{1'b1, 1'b1, 2'd2, FL_A, 8'hC3},
    '{1'b0, 1'b1, 2'd0, FL_A, 8'hC3},
    '{1'b0, 1'b1, 2'd1, FL_B, 8'h34},
    '{1'b1, 1'b1, 2'd3, FL_B, 8'h12},
    '{1'b1, 1'b1, 2'd1, FL_A, 8'h1E},
    '{1'b1, 1'b0, 2'd0, FL_A, 8'h1E},
    '{1'b1, 1'b1, 2'd0, 32'h0000_00FF, 8'hFF}
  };

  logic              clk;
  logic              rst_n;
  logic              mode_i;
  logic              ring_head_i;
  logic              cfg_done_i;
  logic [NUM_Q-1:0]  flags_i;
  logic              strobe_i;
  logic [WSEL_W-1:0] addr_i;
  logic              token_i;
  logic [BUS_W-1:0]  bus_o;
  logic              bus_oe_o;
  logic              sync_o;
  logic              token_o;
  logic              loop_en;
  logic              tok_drv;
  logic              done_flag;

  int n_checks;
  int n_err;

  assign token_i = loop_en ? token_o : tok_drv;

  qstat_flag_scanner dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .ring_head_i (ring_head_i),
    .cfg_done_i  (cfg_done_i),
    .flags_i     (flags_i),
    .strobe_i    (strobe_i),
    .addr_i      (addr_i),
    .token_i     (token_i),
    .bus_o       (bus_o),
    .bus_oe_o    (bus_oe_o),
    .sync_o      (sync_o),
    .token_o     (token_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // bus, oe, sync, token in one call
  task automatic chk_out(input string req, input logic [7:0] eb, input logic eoe,
                         input logic es, input logic et);
    chk({req, " bus"}, 32'(bus_o), 32'(eb));
    chk({req, " oe"}, 32'(bus_oe_o), 32'(eoe));
    chk({req, " sync"}, 32'(sync_o), 32'(es));
    chk({req, " token"}, 32'(token_o), 32'(et));
  endtask

  task automatic do_reset(input logic md, input logic hd);
    @(negedge clk);
    rst_n       = 1'b0;
    mode_i      = md;
    ring_head_i = hd;
    repeat (4) tick();
    chk("R11 reset bus", 32'(bus_o), 32'h0);
    chk("R11 reset sync", 32'(sync_o), 32'h0);
    chk("R11 reset token", 32'(token_o), 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    done_flag = 1'b0;
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    n_checks    = 0;
    n_err       = 0;
    rst_n       = 1'b0;
    mode_i      = 1'b1;
    ring_head_i = 1'b1;
    cfg_done_i  = 1'b0;
    flags_i     = FL_A;
    strobe_i    = 1'b0;
    addr_i      = '0;
    loop_en     = 1'b0;
    tok_drv     = 1'b0;

    // ---------------- direct mode table walk ----------------
    tok_drv = 1'b1;
    do_reset(1'b0, 1'b0);
    repeat (3) tick();
    mode_i = 1'b1; // R1: post-reset change must not matter
    chk_out("R8 default word1", 8'h7F, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) begin
      strobe_i   = TBL[i].stb;
      cfg_done_i = TBL[i].done;
      addr_i     = TBL[i].adr;
      flags_i    = TBL[i].fl;
      tick();
      chk($sformatf("R8/R9 row %0d bus", i), 32'(bus_o), 32'(TBL[i].exp));
      chk($sformatf("R10 row %0d oe", i), 32'(bus_oe_o), 32'h1);
      chk($sformatf("R10 R1 row %0d sync", i), 32'(sync_o), 32'h0);
      chk($sformatf("R10 row %0d token", i), 32'(token_o), 32'h0);
    end
    strobe_i = 1'b0;
    tok_drv  = 1'b0;

    // ---------------- polled, ring head, looped ----------------
    flags_i = FL_A;
    loop_en = 1'b1;
    do_reset(1'b1, 1'b1);
    repeat (3) tick();
    chk_out("R7 R4 R2 head word1", 8'h7F, 1'b1, 1'b1, 1'b0);
    tick();
    chk_out("R3 R2 word2", 8'h1E, 1'b1, 1'b0, 1'b0);
    tick();
    chk_out("R3 R2 word3", 8'hC3, 1'b1, 1'b0, 1'b0);
    tick();
    chk_out("R5 R2 word4", 8'hA5, 1'b1, 1'b0, 1'b1);
    tick();
    chk_out("R3 R4 wrap word1", 8'h7F, 1'b1, 1'b1, 1'b0);
    flags_i = FL_B;
    mode_i  = 1'b0; // R1
    tick();
    chk_out("R3 live word2", 8'h56, 1'b1, 1'b0, 1'b0);
    tick();
    chk_out("R1 still polling word3", 8'h34, 1'b1, 1'b0, 1'b0);
    tick();
    chk_out("R5 word4", 8'h12, 1'b1, 1'b0, 1'b1);
    tick();
    chk_out("R1 R4 word1 again", 8'h78, 1'b1, 1'b1, 1'b0);
    mode_i = 1'b1;

    // ---------------- token withheld ----------------
    loop_en = 1'b0;
    tok_drv = 1'b0;
    repeat (3) tick();
    chk_out("R5 last word before release", 8'h12, 1'b1, 1'b0, 1'b1);
    tick();
    chk_out("R6 idle after pass", 8'h00, 1'b0, 1'b0, 1'b0);
    repeat (3) tick();
    chk_out("R6 stays idle", 8'h00, 1'b0, 1'b0, 1'b0);
    tok_drv = 1'b1;
    tick();
    tok_drv = 1'b0;
    chk_out("R6 token restart", 8'h78, 1'b1, 1'b1, 1'b0);
    repeat (3) tick();
    chk_out("R5 single pass end", 8'h12, 1'b1, 1'b0, 1'b1);
    tick();
    chk_out("R6 idle again", 8'h00, 1'b0, 1'b0, 1'b0);

    // ---------------- polled, not ring head ----------------
    flags_i = FL_A;
    do_reset(1'b1, 1'b0);
    repeat (3) tick();
    chk_out("R7 non-head idle", 8'h00, 1'b0, 1'b0, 1'b0);
    repeat (4) tick();
    chk_out("R7 non-head still idle", 8'h00, 1'b0, 1'b0, 1'b0);
    tok_drv = 1'b1;
    tick();
    tok_drv = 1'b0;
    chk_out("R7 non-head takes token", 8'h7F, 1'b1, 1'b1, 1'b0);
    tick();
    chk_out("R3 non-head word2", 8'h1E, 1'b1, 1'b0, 1'b0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule